// File: doc/BRIEF.md
# PLL Divider Override Loader

This block decides which reference divider (M) and feedback divider (N) a frequency-synthesis PLL receives. At power-on it samples a 4-bit frequency-select strap once. That sample picks one of sixteen built-in default entries. Each entry holds an N, an M and a scale constant P, and the synthesized frequency follows F = P·N/M. Software can then write its own divider pair through a byte-wide management write port: an address, a data byte and a strobe. It can also request that the programmed pair replace the defaults. The PLL takes the programmed pair only when the override is enabled and the pair is legal, meaning M lies in 20..56, N lies in 21..127 and N > M > N/2. In every other case the defaults stay in force. The scale constant P always stays tied to the strapped entry, so the ratios of every clock derived from the same PLL are unchanged.

The register bank also carries a skew-trim bit for the processor clock outputs. It has a combinational read port, so software can read back both bytes. Divider changes reach the PLL through a small sequencer with four states. STRAP is the single cycle after reset in which the strap is sampled. IDLE waits for work. EVAL registers the chosen pair. LOAD copies that pair into the divider outputs. The transitions are:
- STRAP always goes to EVAL.
- IDLE goes to EVAL on a write that hits either divider byte, and otherwise stays in IDLE.
- EVAL stays in EVAL on such a write, and otherwise goes to LOAD.
- LOAD goes to EVAL on such a write, and otherwise goes to IDLE.

The divider outputs therefore change only on the edge that leaves LOAD.

Top module: `pll_div_loader`

## Requirements
- R1: While reset is held, the divider outputs, the skew-trim output and the programmed-source flag are all 0, and reads of both register bytes return 0.
- R2: The strap is sampled on the first clock edge after reset is released and is never sampled again. For strap value i, the default entry is N = 40 + 3i, M = 24 + 2i and P = 95,000,000 + 1,000,000·i. These values reach the divider outputs on the third edge after release.
- R3: A write to address 8 stores data bits 6:0 as the programmed N, and data bit 7 is dropped. A write to address 9 stores bit 7 as the skew trim, bits 6:1 as the programmed M and bit 0 as the override enable. A write to any other address changes nothing.
- R4: The read port returns {0, N} at address 8, {skew, M, enable} at address 9, and 0 at every other address, all combinationally.
- R5: pair_ok is 1 exactly when the stored pair has M in 20..56, N in 21..127, N > M and 2·M > N.
- R6: The divider outputs carry the programmed pair, with using_prog = 1, only when the enable bit is 1 and the pair is legal. Otherwise they carry the strapped default entry, with using_prog = 0.
- R7: After a single write to address 8 or 9 on edge c, the divider outputs keep their old values through edge c+1 and take the new selection on edge c+2.
- R8: Writes on back-to-back edges restart the evaluation, and the outputs settle to the selection made by the last write. A write that lands while a load is under way lets that load finish and then schedules another.
- R9: skew_adj shows byte 9 bit 7 from the edge that writes it onward, with no sequencer delay, and has no effect on the divider outputs.
- R10: p_val follows only the strapped entry. Programming the dividers or changing the strap after reset leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fsel | input | 4 | Frequency-select strap, sampled once after reset |
| wr_en | input | 1 | Write strobe of the management port |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read data byte |
| div_n | output | 7 | Feedback divider presented to the PLL |
| div_m | output | 6 | Reference divider presented to the PLL |
| p_val | output | 32 | Scale constant of the strapped entry |
| skew_adj | output | 1 | Processor clock skew trim (1 = advance) |
| pair_ok | output | 1 | The stored programmed pair is legal |
| using_prog | output | 1 | The divider outputs come from the programmed pair |

## Verification
The bench probes each edge of the legality rule. It covers the smallest legal pair (21, 20), the largest legal M with N = 111, the pair (112, 56) where 2·M equals N, and M equal to N. It also covers M just outside its range and N = 127, which no legal M can pair with. A design with an off-by-one bound or a floored N/2 would either send an illegal pair to the PLL or refuse a legal one. Back-to-back writes and writes spaced two edges apart exercise the restart from EVAL and the re-entry from LOAD. A sequencer that loaded a stale candidate, or dropped the last write, would leave the wrong pair in place. The bench also changes the strap after reset and writes the enable with a legal pair both off and on. This catches a design that re-samples the strap, lets P follow the override, or applies the programmed pair with the enable clear.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    // Sequencer states of the divider loader
    typedef enum logic [1:0] {
        ST_STRAP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_EVAL  = 2'd2,
        ST_LOAD  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/pdl_regs.sv
// Shadow register bank: programmed N byte and control byte, plus read mux.
module pdl_regs #(
    parameter int ADDR_W   = 8,
    parameter int N_W      = 7,
    parameter int M_W      = 6,
    parameter int N_ADDR   = 8,
    parameter int CTL_ADDR = 9,
    localparam int BYTE_W  = M_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [N_W-1:0]    sh_n,
    output logic [M_W-1:0]    sh_m,
    output logic              sh_en,
    output logic              sh_skew,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] A_N   = ADDR_W'(N_ADDR);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
    localparam int               PAD_W = BYTE_W - N_W;

    logic wr_n_byte;
    logic wr_ctl_byte;

    assign wr_n_byte   = wr_en && (wr_addr == A_N);
    assign wr_ctl_byte = wr_en && (wr_addr == A_CTL);
    assign hit         = wr_n_byte || wr_ctl_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_n <= '0;
        end else if (wr_n_byte) begin
            sh_n <= wr_data[N_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_skew <= 1'b0;
            sh_m    <= '0;
            sh_en   <= 1'b0;
        end else if (wr_ctl_byte) begin
            sh_skew <= wr_data[BYTE_W-1];
            sh_m    <= wr_data[M_W:1];
            sh_en   <= wr_data[0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_N) begin
            rd_data = {{PAD_W{1'b0}}, sh_n};
        end else if (rd_addr == A_CTL) begin
            rd_data = {sh_skew, sh_m, sh_en};
        end
    end

endmodule

// File: rtl/pdl_pair_check.sv
// Combinational legality test of a programmed divider pair.
module pdl_pair_check #(
    parameter int N_W   = 7,
    parameter int M_W   = 6,
    parameter int M_MIN = 20,
    parameter int M_MAX = 56,
    parameter int N_MIN = 21,
    parameter int N_MAX = 127
) (
    input  logic [N_W-1:0] n,
    input  logic [M_W-1:0] m,
    output logic           ok
);

    localparam int CW = ((N_W > M_W) ? N_W : M_W) + 2;

    logic [CW-1:0] n_x;
    logic [CW-1:0] m_x;
    logic [CW-1:0] m_dbl;
    logic          m_in_range;
    logic          n_in_range;
    logic          n_above_m;
    logic          m_above_half;

    always_comb begin
        n_x          = CW'(n);
        m_x          = CW'(m);
        m_dbl        = m_x << 1;
        m_in_range   = (m_x >= CW'(M_MIN)) && (m_x <= CW'(M_MAX));
        n_in_range   = (n_x >= CW'(N_MIN)) && (n_x <= CW'(N_MAX));
        n_above_m    = n_x > m_x;
        m_above_half = m_dbl > n_x;
        ok           = m_in_range && n_in_range && n_above_m && m_above_half;
    end

endmodule

// File: rtl/pdl_seq.sv
// Load sequencer: strap capture, candidate evaluation, divider load.
module pdl_seq
    import pdl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic strap_latch,
    output logic cand_en,
    output logic load_en
);

    seq_state_t state_q;
    seq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STRAP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STRAP: state_d = ST_EVAL;
            ST_IDLE:  state_d = hit ? ST_EVAL : ST_IDLE;
            ST_EVAL:  state_d = hit ? ST_EVAL : ST_LOAD;
            ST_LOAD:  state_d = hit ? ST_EVAL : ST_IDLE;
            default:  state_d = ST_STRAP;
        endcase
    end

    always_comb begin
        strap_latch = 1'b0;
        cand_en     = 1'b0;
        load_en     = 1'b0;
        unique case (state_q)
            ST_STRAP: strap_latch = 1'b1;
            ST_IDLE:  ;
            ST_EVAL:  cand_en = !hit;
            ST_LOAD:  load_en = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/pdl_divout.sv
// Strap latch, default table, candidate stage and divider output registers.
module pdl_divout #(
    parameter int SEL_W       = 4,
    parameter int N_W         = 7,
    parameter int M_W         = 6,
    parameter int P_W         = 32,
    parameter int ROM_N_BASE  = 40,
    parameter int ROM_N_STEP  = 3,
    parameter int ROM_M_BASE  = 24,
    parameter int ROM_M_STEP  = 2,
    parameter int ROM_P_BASE  = 95000000,
    parameter int ROM_P_STEP  = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] fsel,
    input  logic             strap_latch,
    input  logic             cand_en,
    input  logic             load_en,
    input  logic [N_W-1:0]   prog_n,
    input  logic [M_W-1:0]   prog_m,
    input  logic             prog_take,
    output logic [N_W-1:0]   div_n,
    output logic [M_W-1:0]   div_m,
    output logic [P_W-1:0]   p_val,
    output logic             using_prog
);

    localparam int ROM_D = 1 << SEL_W;

    logic [N_W-1:0]   rom_n [ROM_D];
    logic [M_W-1:0]   rom_m [ROM_D];
    logic [P_W-1:0]   rom_p [ROM_D];

    logic [SEL_W-1:0] sel_q;
    logic [N_W-1:0]   cand_n;
    logic [M_W-1:0]   cand_m;
    logic             cand_prog;

    for (genvar i = 0; i < ROM_D; i++) begin : g_rom
        assign rom_n[i] = N_W'(ROM_N_BASE + ROM_N_STEP * i);
        assign rom_m[i] = M_W'(ROM_M_BASE + ROM_M_STEP * i);
        assign rom_p[i] = P_W'(ROM_P_BASE + ROM_P_STEP * i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (strap_latch) begin
            sel_q <= fsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_n    <= '0;
            cand_m    <= '0;
            cand_prog <= 1'b0;
        end else if (cand_en) begin
            cand_n    <= prog_take ? prog_n : rom_n[sel_q];
            cand_m    <= prog_take ? prog_m : rom_m[sel_q];
            cand_prog <= prog_take;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_n      <= '0;
            div_m      <= '0;
            using_prog <= 1'b0;
        end else if (load_en) begin
            div_n      <= cand_n;
            div_m      <= cand_m;
            using_prog <= cand_prog;
        end
    end

    assign p_val = rom_p[sel_q];

endmodule

// File: rtl/pll_div_loader.sv
// Top level: PLL divider override loader.
module pll_div_loader #(
    parameter int ADDR_W   = 8,
    parameter int SEL_W    = 4,
    parameter int N_W      = 7,
    parameter int M_W      = 6,
    parameter int P_W      = 32,
    parameter int N_ADDR   = 8,
    parameter int CTL_ADDR = 9,
    parameter int M_MIN    = 20,
    parameter int M_MAX    = 56,
    parameter int N_MIN    = 21,
    parameter int N_MAX    = 127,
    localparam int BYTE_W  = M_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  fsel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [N_W-1:0]    div_n,
    output logic [M_W-1:0]    div_m,
    output logic [P_W-1:0]    p_val,
    output logic              skew_adj,
    output logic              pair_ok,
    output logic              using_prog
);

    logic [N_W-1:0] sh_n;
    logic [M_W-1:0] sh_m;
    logic           sh_en;
    logic           sh_skew;
    logic           hit;
    logic           strap_latch;
    logic           cand_en;
    logic           load_en;
    logic           prog_take;

    pdl_regs #(
        .ADDR_W   (ADDR_W),
        .N_W      (N_W),
        .M_W      (M_W),
        .N_ADDR   (N_ADDR),
        .CTL_ADDR (CTL_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sh_n    (sh_n),
        .sh_m    (sh_m),
        .sh_en   (sh_en),
        .sh_skew (sh_skew),
        .hit     (hit)
    );

    pdl_pair_check #(
        .N_W   (N_W),
        .M_W   (M_W),
        .M_MIN (M_MIN),
        .M_MAX (M_MAX),
        .N_MIN (N_MIN),
        .N_MAX (N_MAX)
    ) u_check (
        .n  (sh_n),
        .m  (sh_m),
        .ok (pair_ok)
    );

    pdl_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .strap_latch (strap_latch),
        .cand_en     (cand_en),
        .load_en     (load_en)
    );

    assign prog_take = sh_en && pair_ok;

    pdl_divout #(
        .SEL_W (SEL_W),
        .N_W   (N_W),
        .M_W   (M_W),
        .P_W   (P_W)
    ) u_divout (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsel        (fsel),
        .strap_latch (strap_latch),
        .cand_en     (cand_en),
        .load_en     (load_en),
        .prog_n      (sh_n),
        .prog_m      (sh_m),
        .prog_take   (prog_take),
        .div_n       (div_n),
        .div_m       (div_m),
        .p_val       (p_val),
        .using_prog  (using_prog)
    );

    assign skew_adj = sh_skew;

endmodule

// File: rtl/pdl_checker.sv
// Assertion checker bound to the loader top.
module pdl_checker #(
    parameter int ADDR_W   = 8,
    parameter int N_W      = 7,
    parameter int M_W      = 6,
    parameter int P_W      = 32,
    parameter int CTL_ADDR = 9,
    parameter int M_MIN    = 20,
    parameter int M_MAX    = 56,
    parameter int N_MIN    = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_skew_bit,
    input logic [N_W-1:0]    div_n,
    input logic [M_W-1:0]    div_m,
    input logic [P_W-1:0]    p_val,
    input logic              skew_adj,
    input logic              pair_ok,
    input logic              using_prog,
    input logic              load_en,
    input logic              strap_latch,
    input logic [N_W-1:0]    sh_n,
    input logic [M_W-1:0]    sh_m
);

    // R1: quiet outputs while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (div_n == '0 && div_m == '0 && !skew_adj && !using_prog);
        end
    end

    // R5: a legal flag implies the stored pair is inside its ranges
    a_r5_ok_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ok |-> (int'(sh_m) >= M_MIN && int'(sh_m) <= M_MAX &&
                     int'(sh_n) >= N_MIN && int'(sh_n) > int'(sh_m)));

    // R2: any loaded pair, default or programmed, obeys the ordering rule
    a_r2_loaded_pair_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (div_n != '0) |-> (int'(div_n) > int'(div_m) && 2 * int'(div_m) > int'(div_n)));

    // R6: a programmed source always carries an in-range pair
    a_r6_prog_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        using_prog |-> (int'(div_m) >= M_MIN && int'(div_m) <= M_MAX && int'(div_n) >= N_MIN));

    // R7: dividers move only on the edge leaving the load state
    a_r7_hold_outside_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(div_n) && $stable(div_m) && $stable(using_prog)));

    // R10: scale constant fixed once the strap is taken
    a_r10_p_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_latch |=> $stable(p_val));

    // R9: skew trim follows a control-byte write on the next edge
    a_r9_skew_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(CTL_ADDR)) |=> (skew_adj == $past(wr_skew_bit)));

endmodule

bind pll_div_loader pdl_checker #(
    .ADDR_W   (ADDR_W),
    .N_W      (N_W),
    .M_W      (M_W),
    .P_W      (P_W),
    .CTL_ADDR (CTL_ADDR),
    .M_MIN    (M_MIN),
    .M_MAX    (M_MAX),
    .N_MIN    (N_MIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_skew_bit (wr_data[BYTE_W-1]),
    .div_n       (div_n),
    .div_m       (div_m),
    .p_val       (p_val),
    .skew_adj    (skew_adj),
    .pair_ok     (pair_ok),
    .using_prog  (using_prog),
    .load_en     (load_en),
    .strap_latch (strap_latch),
    .sh_n        (sh_n),
    .sh_m        (sh_m)
);

// File: tb/pll_div_loader_tb.sv
module pll_div_loader_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fsel = 4'd5;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_addr = 8'd0;
    logic [7:0] rd_data;
    logic [6:0] div_n;
    logic [5:0] div_m;
    logic [31:0] p_val;
    logic       skew_adj;
    logic       pair_ok;
    logic       using_prog;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pll_div_loader u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsel       (fsel),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .div_n      (div_n),
        .div_m      (div_m),
        .p_val      (p_val),
        .skew_adj   (skew_adj),
        .pair_ok    (pair_ok),
        .using_prog (using_prog)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    function automatic int rom_n(int i); return 40 + 3 * i; endfunction
    function automatic int rom_m(int i); return 24 + 2 * i; endfunction
    function automatic int rom_p(int i); return 95000000 + 1000000 * i; endfunction
    function automatic bit legal(int n, int m);
        return (m >= 20) && (m <= 56) && (n >= 21) && (n <= 127) && (n > m) && (2 * m > n);
    endfunction

    int  mn, mb9, mstrap, mdn, mdm;
    bit  mprog, first_edge, live;
    int  cyc;
    int  q_due[$];
    int  q_n[$];
    int  q_m[$];
    bit  q_p[$];

    function automatic void push_choice(int due);
        int m_val;
        m_val = (mb9 >> 1) & 63;
        q_due.push_back(due);
        if ((mb9 & 1) == 1 && legal(mn, m_val)) begin
            q_n.push_back(mn); q_m.push_back(m_val); q_p.push_back(1'b1);
        end else begin
            q_n.push_back(rom_n(mstrap)); q_m.push_back(rom_m(mstrap)); q_p.push_back(1'b0);
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mn = 0; mb9 = 0; mstrap = 0; mdn = 0; mdm = 0; mprog = 0;
            q_due.delete(); q_n.delete(); q_m.delete(); q_p.delete();
            first_edge = 1'b1; live = 1'b1; cyc = 0;
        end else begin
            cyc++;
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                void'(q_due.pop_front());
                mdn = q_n.pop_front();
                mdm = q_m.pop_front();
                mprog = q_p.pop_front();
            end
            if (first_edge) begin
                first_edge = 1'b0;
                mstrap = int'(fsel);
                push_choice(cyc + 2);
            end
            if (wr_en && (wr_addr == 8'd8 || wr_addr == 8'd9)) begin
                if (wr_addr == 8'd8) mn = int'(wr_data[6:0]);
                else mb9 = int'(wr_data);
                if (q_due.size() > 0 && q_due[$] == cyc + 1) begin
                    void'(q_due.pop_back()); void'(q_n.pop_back());
                    void'(q_m.pop_back()); void'(q_p.pop_back());
                end
                push_choice(cyc + 2);
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (live && !done) begin
            chk("R7 model div_n", div_n, mdn);
            chk("R7 model div_m", div_m, mdm);
            chk("R6 model using_prog", using_prog, mprog);
            chk("R9 model skew_adj", skew_adj, (mb9 >> 7) & 1);
            chk("R5 model pair_ok", pair_ok, legal(mn, (mb9 >> 1) & 63));
            chk("R10 model p_val", p_val, rom_p(mstrap));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input int a, input int exp);
        rd_addr = 8'(a);
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic try_pair(input int n, input int m, input bit exp_ok);
        wr(8, n);
        idle(3);
        wr(9, (m << 1) | 1);
        idle(3);
        chk("R5 boundary pair_ok", pair_ok, exp_ok);
        chk("R6 boundary div_n", div_n, exp_ok ? n : rom_n(5));
        chk("R6 boundary div_m", div_m, exp_ok ? m : rom_m(5));
    endtask

    initial begin
        // R1: reset state
        idle(3);
        chk("R1 div_n in reset", div_n, 0);
        chk("R1 div_m in reset", div_m, 0);
        chk("R1 skew in reset", skew_adj, 0);
        chk("R1 using_prog in reset", using_prog, 0);
        rd_chk("R1 read byte 8 in reset", 8, 0);
        rd_chk("R1 read byte 9 in reset", 9, 0);

        // R2: strap sampled on the release edge, defaults after three edges
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fsel = 4'd12;
        chk("R2 div_n before load", div_n, 0);
        @(negedge clk);
        chk("R2 div_n still before load", div_n, 0);
        @(negedge clk);
        chk("R2 default div_n", div_n, 55);
        chk("R2 default div_m", div_m, 34);
        chk("R2 default p_val", p_val, 100000000);
        idle(4);
        chk("R10 p_val ignores later strap", p_val, 100000000);

        // R3 / R4: register capture and read-back
        wr(8, 8'hC6);
        rd_chk("R3 byte 8 drops bit 7", 8, 8'h46);
        idle(3);
        wr(3, 8'hFF);
        rd_chk("R3 stray write leaves byte 8", 8, 8'h46);
        rd_chk("R3 stray write leaves byte 9", 9, 0);
        rd_chk("R4 unmapped address reads 0", 3, 0);
        idle(3);

        // R6 / R7: legal program with override enable
        wr(8, 100);
        idle(3);
        wr(9, (55 << 1) | 1);
        chk("R7 hold after write edge", div_n, 55);
        @(negedge clk);
        chk("R7 hold one edge later", div_n, 55);
        @(negedge clk);
        chk("R7 new div_n two edges later", div_n, 100);
        chk("R6 programmed div_m", div_m, 55);
        chk("R6 using_prog set", using_prog, 1);
        rd_chk("R4 read byte 9", 9, 8'h6F);

        // R6: enable clear with a legal pair keeps defaults
        wr(9, 55 << 1);
        idle(3);
        chk("R6 enable clear div_n", div_n, 55);
        chk("R6 enable clear div_m", div_m, 34);
        chk("R6 enable clear using_prog", using_prog, 0);
        chk("R5 legal pair with enable clear", pair_ok, 1);

        // R5 / R6: legality boundaries
        try_pair(21, 20, 1'b1);
        try_pair(111, 56, 1'b1);
        try_pair(112, 56, 1'b0);
        try_pair(40, 40, 1'b0);
        try_pair(41, 20, 1'b0);
        try_pair(30, 19, 1'b0);
        try_pair(100, 57, 1'b0);
        try_pair(127, 56, 1'b0);

        // R8: back-to-back writes restart evaluation
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'd8; wr_data = 8'd90;
        @(negedge clk);
        wr_addr = 8'd9; wr_data = 8'((50 << 1) | 1);
        @(negedge clk);
        wr_data = 8'((46 << 1) | 1);
        @(negedge clk);
        wr_en = 1'b0;
        idle(4);
        chk("R8 burst settles div_n", div_n, 90);
        chk("R8 burst settles div_m", div_m, 46);

        // R8 / R9: write landing in the load state, skew set
        wr(8, 80);
        wr(9, 8'h80 | (41 << 1) | 1);
        chk("R9 skew visible after write edge", skew_adj, 1);
        idle(4);
        chk("R8 load-state write div_n", div_n, 80);
        chk("R8 load-state write div_m", div_m, 41);

        // R9: skew alone does not touch dividers
        wr(9, 8'h80 | (41 << 1));
        idle(4);
        chk("R9 skew kept", skew_adj, 1);
        chk("R9 defaults restored div_n", div_n, 55);
        chk("R10 p_val after programming", p_val, 100000000);

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule